// File: doc/BRIEF.md
# Reset Source Sequencer

This block sequences the system reset of a chip from three inputs: a supply-good level from an analog monitor, a monitor-enable strap and an active-low external reset pin. It drives one active-low system reset. After the supply becomes good, it keeps that reset asserted for a fixed hold time of `HOLD_CYCLES` clock cycles. The default is one tenth of a second, `CLK_HZ/10`. A reset caused by the pin lasts only as long as the pin stays low. Every cause ends in the same run state.

Software tells the causes apart by reading an 8-bit flag register through a registered read port. Bit 1 is the power flag. It is set when the system leaves a supply-monitor reset and cleared when it leaves a pin reset. Bit 0 is the pin flag, and it works the other way round. All other bits read 0. A core power-up clear `pu_clr_n` initialises the sequencer's own flops.

The controller has four states:
- `ST_POWER` waits for the supply.
- `ST_HOLD` counts the hold time.
- `ST_EXT` follows the pin.
- `ST_RUN` releases the system.

Its transitions are:
- POWER→HOLD: the supply is good, or the monitor is disabled.
- HOLD→POWER, RUN→POWER and EXT→POWER: the supply drops while the monitor is enabled. This takes priority over every other transition.
- HOLD→RUN: the hold count has completed.
- RUN→EXT: a filtered pin request arrives.
- EXT→RUN: the synchronised pin reads high again.

Top module: `rst_cause_seq`

## Requirements
- R1: While `pu_clr_n` is low and afterwards until the supply is good, `sys_rst_n` is 0. A read in that period returns 8'h00.
- R2: With `mon_en`=1, `sys_rst_n` rises at exactly the `HOLD_CYCLES`+3rd rising clock edge after `supply_ok` goes high. The edges are counted from the first edge that samples `supply_ok` high. `HOLD_CYCLES` defaults to `CLK_HZ/10`.
- R3: In run with `mon_en`=1, a low `supply_ok` drives `sys_rst_n` to 0 within 3 edges. It stays 0 while the supply is low. Recovery follows the R2 timing.
- R4: In run with `mon_en`=0, a drop of `supply_ok` does not assert `sys_rst_n` and does not change the flags.
- R5: An `ext_rst_n` low seen on at least two consecutive rising edges asserts `sys_rst_n`. It stays asserted while the pin is low. `sys_rst_n` returns high within 3 edges of the pin going high, with no hold time.
- R6: An `ext_rst_n` low seen on only one rising edge is ignored. `sys_rst_n` stays 1 and the flags are unchanged.
- R7: Flag register layout: bit 1 is the power flag and bit 0 is the pin flag, with bits 7:2 always 0. Leaving a supply-monitor reset gives 8'h02. Leaving a pin reset gives 8'h01.
- R8: A rising edge with `rd_en`=1 loads `rd_data` with the flags. `rd_data` holds its value while `rd_en` is 0. Reads never change the flags.
- R9: Pin activity during a supply hold neither extends the hold nor changes the cause. A supply drop during a pin reset turns it into a supply-monitor reset, which exits with the R2 timing and 8'h02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| pu_clr_n | input | 1 | Core power-up clear of the sequencer, active low, asynchronous |
| supply_ok | input | 1 | Supply-good level from the analog monitor, asynchronous |
| mon_en | input | 1 | Monitor enable; 0 masks supply drops |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| rd_en | input | 1 | Read strobe for the flag register |
| rd_data | output | 8 | Registered flag read data |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The hardest situation to reach from the ports is a reset cause changing partway through a sequence. The bench reaches it with two orderings. In the first, a pin pulse is placed in the middle of a running hold count. In the second, the supply is dropped while a long pin reset is in progress. In both cases it checks the exit cycle and the flag value. The pin filter boundary is swept over low widths of one to six cycles. The hold time is measured edge by edge against `HOLD_CYCLES`+3.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [1:0] {
        ST_POWER = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_EXT   = 2'd3
    } rcs_state_t;

    localparam int FLAG_W   = 8;
    localparam int PIN_BIT  = 0;
    localparam int PWR_BIT  = 1;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[0] <= RST_VAL;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/rcs_hold_timer.sv
module rcs_hold_timer #(
    parameter int HOLD_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    // R2: the count never runs past the hold length
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R2: leaving run always restarts the count
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/rst_cause_seq.sv
module rst_cause_seq
    import rcs_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int HOLD_CYCLES = CLK_HZ / 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              pu_clr_n,
    input  logic              supply_ok,
    input  logic              mon_en,
    input  logic              ext_rst_n,
    input  logic              rd_en,
    output logic [FLAG_W-1:0] rd_data,
    output logic              sys_rst_n
);
    localparam logic [FLAG_W-1:0] FLAGS_PWR = FLAG_W'(1) << PWR_BIT;
    localparam logic [FLAG_W-1:0] FLAGS_PIN = FLAG_W'(1) << PIN_BIT;

    logic [2:0] sync_q;
    logic       supply_s, mon_s, pin_s, pin_prev, pin_req, supply_lost;
    logic       hold_done, cause_pwr;
    logic [FLAG_W-1:0] flags;
    rcs_state_t state, state_nxt;

    rcs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (pu_clr_n),
        .d     ({ext_rst_n, mon_en, supply_ok}),
        .q     (sync_q)
    );
    assign supply_s = sync_q[0];
    assign mon_s    = sync_q[1];
    assign pin_s    = sync_q[2];

    always_ff @(posedge clk or negedge pu_clr_n) begin
        if (!pu_clr_n) pin_prev <= 1'b1;
        else           pin_prev <= pin_s;
    end
    assign pin_req     = !pin_s && !pin_prev;
    assign supply_lost = mon_s && !supply_s;

    rcs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (pu_clr_n),
        .run   (state == ST_HOLD),
        .done  (hold_done)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_POWER: if (!mon_s || supply_s) state_nxt = ST_HOLD;
            ST_HOLD:  if (supply_lost)        state_nxt = ST_POWER;
                      else if (hold_done)     state_nxt = ST_RUN;
            ST_RUN:   if (supply_lost)        state_nxt = ST_POWER;
                      else if (pin_req)       state_nxt = ST_EXT;
            ST_EXT:   if (supply_lost)        state_nxt = ST_POWER;
                      else if (pin_s)         state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge pu_clr_n) begin
        if (!pu_clr_n) begin
            state     <= ST_POWER;
            cause_pwr <= 1'b1;
            flags     <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt == ST_POWER)                         cause_pwr <= 1'b1;
            else if (state_nxt == ST_EXT && state != ST_EXT)   cause_pwr <= 1'b0;
            if (state_nxt == ST_RUN && state != ST_RUN)
                flags <= cause_pwr ? FLAGS_PWR : FLAGS_PIN;
        end
    end

    always_ff @(posedge clk or negedge pu_clr_n) begin
        if (!pu_clr_n)  rd_data <= '0;
        else if (rd_en) rd_data <= flags;
    end

    always_comb begin
        sys_rst_n = (state == ST_RUN);
    end

    // R3: an enabled supply loss in run pulls reset on the next edge
    p_drop_r3: assert property (@(posedge clk) disable iff (!pu_clr_n)
        (sys_rst_n && supply_lost) |=> !sys_rst_n);
    // R4: a disabled monitor keeps run alive without a pin request
    p_masked_r4: assert property (@(posedge clk) disable iff (!pu_clr_n)
        (sys_rst_n && !mon_s && !pin_req) |=> sys_rst_n);
    // R2: release only follows a completed hold or a pin release
    p_release_r2: assert property (@(posedge clk) disable iff (!pu_clr_n)
        $rose(sys_rst_n) |-> ($past(hold_done) || $past(state == ST_EXT)));
    // R7: flags on release reflect the recorded cause
    p_flag_r7: assert property (@(posedge clk) disable iff (!pu_clr_n)
        $rose(sys_rst_n) |-> (flags == ($past(cause_pwr) ? FLAGS_PWR : FLAGS_PIN)));
    // R8: flags stay put through run, read or not
    p_read_r8: assert property (@(posedge clk) disable iff (!pu_clr_n)
        (sys_rst_n && $past(sys_rst_n)) |-> $stable(flags));
endmodule

// File: tb/rst_cause_seq_bench.sv
module rst_cause_seq_bench;
    localparam int CLK_HZ = 500;
    localparam int N      = CLK_HZ / 10;

    logic       clk = 1'b0;
    logic       pu_clr_n, supply_ok, mon_en, ext_rst_n, rd_en;
    logic [7:0] rd_data;
    logic       sys_rst_n;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    rst_cause_seq #(.CLK_HZ(CLK_HZ)) u_rst_cause_seq (
        .clk       (clk),
        .pu_clr_n  (pu_clr_n),
        .supply_ok (supply_ok),
        .mon_en    (mon_en),
        .ext_rst_n (ext_rst_n),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .sys_rst_n (sys_rst_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic read_flags(output logic [7:0] v);
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!sys_rst_n && n < 1000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] f;
        logic [7:0] exp_f;
        int         n;
        logic       saw_low;

        pu_clr_n = 1'b0; supply_ok = 1'b0; mon_en = 1'b1;
        ext_rst_n = 1'b1; rd_en = 1'b0;
        tick(3);
        chk("R1 reset during clear", sys_rst_n, 0);
        pu_clr_n = 1'b1;
        tick(5);
        chk("R1 reset before supply", sys_rst_n, 0);
        read_flags(f);
        chk("R1 flags after clear", f, 8'h00);

        supply_ok = 1'b1;
        measure(n);
        chk("R2 power-up hold edges", n, N + 3);
        read_flags(f);
        chk("R7 power flag after power-up", f, 8'h02);
        tick(7);
        chk("R8 rd_data holds", rd_data, 8'h02);
        read_flags(f);
        chk("R8 reread unchanged", f, 8'h02);

        supply_ok = 1'b0;
        tick(3);
        chk("R3 drop asserts reset", sys_rst_n, 0);
        tick(10);
        chk("R3 stays low while supply low", sys_rst_n, 0);
        supply_ok = 1'b1;
        measure(n);
        chk("R3 recovery hold edges", n, N + 3);
        read_flags(f);
        chk("R3 flags after brownout", f, 8'h02);

        exp_f = 8'h02;
        for (int d = 1; d <= 6; d++) begin
            saw_low = 1'b0;
            ext_rst_n = 1'b0;
            for (int i = 0; i < d; i++) begin
                tick(1);
                if (!sys_rst_n) saw_low = 1'b1;
            end
            if (d == 6) chk("R5 held while pin low", sys_rst_n, 0);
            ext_rst_n = 1'b1;
            for (int i = 0; i < 4; i++) begin
                tick(1);
                if (!sys_rst_n) saw_low = 1'b1;
            end
            chk(d >= 2 ? "R5 pin reset seen" : "R6 glitch ignored", saw_low, d >= 2);
            chk("R5 released after pin high", sys_rst_n, 1);
            if (d >= 2) exp_f = 8'h01;
            read_flags(f);
            chk(d >= 2 ? "R7 pin flag" : "R6 flags unchanged", f, exp_f);
        end

        mon_en = 1'b0;
        tick(4);
        supply_ok = 1'b0;
        saw_low = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (!sys_rst_n) saw_low = 1'b1;
        end
        chk("R4 masked drop", saw_low, 0);
        read_flags(f);
        chk("R4 flags untouched", f, 8'h01);
        supply_ok = 1'b1;
        tick(4);
        mon_en = 1'b1;
        tick(4);
        chk("R4 still running", sys_rst_n, 1);

        supply_ok = 1'b0;
        tick(5);
        supply_ok = 1'b1;
        n = 0;
        do begin
            if (n == 10) ext_rst_n = 1'b0;
            if (n == 15) ext_rst_n = 1'b1;
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!sys_rst_n && n < 1000);
        chk("R9 pin during hold keeps timing", n, N + 3);
        read_flags(f);
        chk("R9 pin during hold keeps cause", f, 8'h02);

        ext_rst_n = 1'b0;
        tick(6);
        supply_ok = 1'b0;
        tick(6);
        ext_rst_n = 1'b1;
        tick(6);
        chk("R9 supply low holds reset", sys_rst_n, 0);
        supply_ok = 1'b1;
        measure(n);
        chk("R9 takeover hold edges", n, N + 3);
        read_flags(f);
        chk("R9 takeover flags", f, 8'h02);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule